// File: doc/BRIEF.md
# LCD Row Scan and Frame Timing Generator

This block paces the row scan of a multiplexed dot-matrix LCD. Each pulse on `line_step` marks the start of one segment-clock period. On that pulse a line counter moves to the next common line. The counter wraps after 16 lines or after 32 lines, depending on the duty setting. A programmable start line is added to the counter, modulo 32, to give the display-RAM row that is fetched for the current common line. At each wrap the block toggles a frame polarity signal, which the downstream drivers use to alternate the drive level.

A one-cycle latch strobe follows every accepted step. The RAM word present on `seg_data_in` during that strobe cycle is captured as the segment pattern for the line. The segment pattern can be mirrored onto the outputs, and the common outputs are one-hot on the active line. Display-off blanks both the segment and the common outputs. Static drive with the display on lights every segment and every common. Static drive with the display off is a power-save state, in which the scan halts.

A chip can act as master, which generates the frame signal, or as slave. A slave copies the master's frame signal and realigns its own line counter to line 0 on every edge of that signal. The settings come from a command decoder. The RAM read path lies outside this block.

Top module: `lcd_scan_timing`

## Requirements
- R1: Each accepted `line_step` advances `com_idx` by one. After line 15 (`duty_full`=0) or line 31 (`duty_full`=1) the counter returns to 0. If `com_idx` is above the current limit (for example after the duty was reduced), the next step returns it to 0.
- R2: `ram_row` always equals (`com_idx` + `start_line`) mod 32.
- R3: In master mode (`slave_mode`=0), `fr_out` inverts on the same edge at which the counter wraps to 0, and holds its value on every other edge.
- R4: `latch_stb` is high for exactly the one cycle that follows each accepted step. `seg_out` takes the `seg_data_in` value present during that cycle, at the clock edge that ends the cycle.
- R5: With `col_reverse`=0, `seg_out[i]` is latched bit i. With `col_reverse`=1, `seg_out[i]` is latched bit NSEG-1-i.
- R6: With the display on and static drive off, `com_out` has only bit `com_idx` set when `com_idx` < NCOM, and is all zero otherwise.
- R7: With `disp_on`=0 and `static_drv`=0, `com_out` and `seg_out` are all zero, and scanning continues.
- R8: With `disp_on`=1 and `static_drv`=1, every bit of `com_out` and every bit of `seg_out` is 1.
- R9: With `disp_on`=0 and `static_drv`=1 (power save), steps are ignored: `com_idx` and `fr_out` hold their values and `latch_stb` stays 0.
- R10: In slave mode, `fr_out` equals the previous cycle's `fr_in`. Any change of `fr_in` forces `com_idx` to 0 at the next edge, and this overrides a step in the same cycle. A wrap does not toggle `fr_out`.
- R11: After reset, `com_idx`=0, `fr_out`=0, `latch_stb`=0 and the latched segment pattern is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_step | input | 1 | One-cycle pulse at the start of each segment-clock period |
| duty_full | input | 1 | 0: 16-line scan, 1: 32-line scan |
| start_line | input | 5 | RAM row shown on common line 0 |
| disp_on | input | 1 | 1: display enabled |
| static_drv | input | 1 | Static drive select |
| col_reverse | input | 1 | 1: mirror the segment order |
| slave_mode | input | 1 | 1: follow an external frame signal |
| fr_in | input | 1 | Frame signal from the master chip |
| seg_data_in | input | NSEG | RAM word for row `ram_row` |
| com_idx | output | 5 | Current common line |
| ram_row | output | 5 | Display-RAM row to read |
| latch_stb | output | 1 | Segment data latch strobe |
| fr_out | output | 1 | Frame polarity signal |
| com_out | output | NCOM | Logical common pattern |
| seg_out | output | NSEG | Logical segment pattern |

## Verification
In slave mode, a line step and a change of the incoming frame signal can arrive in the same cycle. The bench provokes this by raising `fr_in` and `line_step` together at one falling edge. It judges the result after the next rising edge: `com_idx` must be 0 rather than the stepped value, and `fr_out` must already show the new level. A second overlap is a duty reduction while the counter sits above the new limit. The bench expects the next step to wrap the counter to 0 and to toggle the frame signal in the same edge.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
    localparam int SCAN_LINES = 32;
    localparam int LINE_W     = $clog2(SCAN_LINES);

    typedef logic [LINE_W-1:0] line_t;

    typedef struct packed {
        line_t line;     // current common line
        logic  fr;       // frame polarity
        logic  fr_seen;  // last sampled external frame level
        logic  stb;      // latch strobe
    } ctr_state_t;
endpackage

// File: rtl/scan_line_ctr.sv
module scan_line_ctr
    import lcd_scan_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  line_step,
    input  logic  duty_full,
    input  logic  psave,
    input  logic  slave_mode,
    input  logic  fr_in,
    output line_t line,
    output logic  fr,
    output logic  stb
);
    localparam line_t LIM_FULL = line_t'(SCAN_LINES - 1);
    localparam line_t LIM_HALF = line_t'(SCAN_LINES / 2 - 1);

    ctr_state_t st_d, st_q;
    line_t      lim;
    logic       advance;
    logic       fr_edge;

    always_comb begin
        lim     = duty_full ? LIM_FULL : LIM_HALF;
        advance = line_step && !psave;
        fr_edge = slave_mode && (fr_in != st_q.fr_seen);

        st_d         = st_q;
        st_d.fr_seen = fr_in;
        st_d.stb     = advance;

        if (advance) begin
            if (st_q.line >= lim) begin
                st_d.line = '0;
                if (!slave_mode) begin
                    st_d.fr = ~st_q.fr;
                end
            end else begin
                st_d.line = st_q.line + line_t'(1);
            end
        end

        if (slave_mode) begin
            st_d.fr = fr_in;
        end
        if (fr_edge) begin
            st_d.line = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line = st_q.line;
    assign fr   = st_q.fr;
    assign stb  = st_q.stb;
endmodule

// File: rtl/scan_row_map.sv
module scan_row_map
    import lcd_scan_pkg::*;
(
    input  line_t line,
    input  line_t start_line,
    output line_t ram_row
);
    line_t row_d;

    always_comb begin
        row_d = line + start_line;   // wraps modulo SCAN_LINES
    end

    assign ram_row = row_d;
endmodule

// File: rtl/scan_com_drv.sv
module scan_com_drv
    import lcd_scan_pkg::*;
#(
    parameter int NCOM = 16
) (
    input  line_t           line,
    input  logic            disp_on,
    input  logic            static_drv,
    output logic [NCOM-1:0] com_out
);
    for (genvar i = 0; i < NCOM; i++) begin : g_com
        assign com_out[i] = disp_on && (static_drv || (line == line_t'(i)));
    end
endmodule

// File: rtl/scan_seg_path.sv
module scan_seg_path #(
    parameter int NSEG = 61
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            latch_en,
    input  logic [NSEG-1:0] seg_in,
    input  logic            disp_on,
    input  logic            static_drv,
    input  logic            reverse,
    output logic [NSEG-1:0] seg_out
);
    logic [NSEG-1:0] seg_d, seg_q;
    logic [NSEG-1:0] seg_mirror;

    always_comb begin
        seg_d = latch_en ? seg_in : seg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q <= '0;
        end else begin
            seg_q <= seg_d;
        end
    end

    for (genvar i = 0; i < NSEG; i++) begin : g_mirror
        assign seg_mirror[i] = seg_q[NSEG-1-i];
    end

    always_comb begin
        if (!disp_on) begin
            seg_out = '0;
        end else if (static_drv) begin
            seg_out = '1;
        end else if (reverse) begin
            seg_out = seg_mirror;
        end else begin
            seg_out = seg_q;
        end
    end
endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
    import lcd_scan_pkg::*;
#(
    parameter int NCOM = 16,
    parameter int NSEG = 61
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_step,
    input  logic              duty_full,
    input  logic [LINE_W-1:0] start_line,
    input  logic              disp_on,
    input  logic              static_drv,
    input  logic              col_reverse,
    input  logic              slave_mode,
    input  logic              fr_in,
    input  logic [NSEG-1:0]   seg_data_in,
    output logic [LINE_W-1:0] com_idx,
    output logic [LINE_W-1:0] ram_row,
    output logic              latch_stb,
    output logic              fr_out,
    output logic [NCOM-1:0]   com_out,
    output logic [NSEG-1:0]   seg_out
);
    logic  psave;
    line_t line_w;
    logic  stb_w;

    assign psave = !disp_on && static_drv;

    scan_line_ctr u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_step  (line_step),
        .duty_full  (duty_full),
        .psave      (psave),
        .slave_mode (slave_mode),
        .fr_in      (fr_in),
        .line       (line_w),
        .fr         (fr_out),
        .stb        (stb_w)
    );

    scan_row_map u_map (
        .line       (line_w),
        .start_line (start_line),
        .ram_row    (ram_row)
    );

    scan_com_drv #(.NCOM(NCOM)) u_com (
        .line       (line_w),
        .disp_on    (disp_on),
        .static_drv (static_drv),
        .com_out    (com_out)
    );

    scan_seg_path #(.NSEG(NSEG)) u_seg (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_en   (stb_w),
        .seg_in     (seg_data_in),
        .disp_on    (disp_on),
        .static_drv (static_drv),
        .reverse    (col_reverse),
        .seg_out    (seg_out)
    );

    assign com_idx   = line_w;
    assign latch_stb = stb_w;
endmodule

// File: rtl/lcd_scan_checker.sv
module lcd_scan_checker
    import lcd_scan_pkg::*;
#(
    parameter int NCOM = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_step,
    input logic              duty_full,
    input logic              disp_on,
    input logic              static_drv,
    input logic              slave_mode,
    input logic              fr_in,
    input logic [LINE_W-1:0] com_idx,
    input logic              latch_stb,
    input logic              fr_out,
    input logic [NCOM-1:0]   com_out
);
    logic        saver;
    logic [LINE_W-1:0] top_line;

    assign saver    = !disp_on && static_drv;
    assign top_line = duty_full ? LINE_W'(SCAN_LINES - 1) : LINE_W'(SCAN_LINES / 2 - 1);

    assert_step_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_step && !saver && !slave_mode && com_idx < top_line)
        |=> com_idx == $past(com_idx) + LINE_W'(1));

    assert_fr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !line_step) |=> $stable(fr_out));

    assert_no_stray_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !line_step |=> !latch_stb);

    assert_com_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !static_drv |-> $onehot0(com_out));

    assert_psave_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (saver && !slave_mode) |=> ($stable(com_idx) && !latch_stb));

    assert_slave_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |=> fr_out == $past(fr_in));
endmodule

bind lcd_scan_timing lcd_scan_checker #(.NCOM(NCOM)) u_chk (.*);

// File: tb/tb_lcd_scan_timing.sv
`timescale 1ns/1ps
module tb_lcd_scan_timing;
    localparam int NCOM = 16;
    localparam int NSEG = 61;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            line_step = 1'b0;
    logic            duty_full = 1'b0;
    logic [4:0]      start_line = '0;
    logic            disp_on = 1'b1;
    logic            static_drv = 1'b0;
    logic            col_reverse = 1'b0;
    logic            slave_mode = 1'b0;
    logic            fr_in = 1'b0;
    logic [NSEG-1:0] seg_data_in;
    logic [4:0]      com_idx;
    logic [4:0]      ram_row;
    logic            latch_stb;
    logic            fr_out;
    logic [NCOM-1:0] com_out;
    logic [NSEG-1:0] seg_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lcd_scan_timing #(.NCOM(NCOM), .NSEG(NSEG)) dut (.*);

    function automatic logic [NSEG-1:0] ram_word(input logic [4:0] row);
        logic [63:0] w;
        w = 64'h9E37_79B9_7F4A_7C15 * (64'(row) + 64'd1);
        return w[NSEG-1:0];
    endfunction

    function automatic logic [NSEG-1:0] mirror(input logic [NSEG-1:0] v);
        logic [NSEG-1:0] r;
        for (int i = 0; i < NSEG; i++) r[i] = v[NSEG-1-i];
        return r;
    endfunction

    always_comb seg_data_in = ram_word(ram_row);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        line_step = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic step();
        line_step = 1'b1;
        @(negedge clk);
        line_step = 1'b0;
    endtask

    // {duty, start, steps, exp_line, exp_row, exp_fr}
    localparam logic [24:0] VECS [0:6] = '{
        {1'b0, 5'd0,  8'd5,  5'd5,  5'd5,  1'b0},
        {1'b0, 5'd3,  8'd16, 5'd0,  5'd3,  1'b1},
        {1'b1, 5'd10, 8'd20, 5'd20, 5'd30, 1'b0},
        {1'b1, 5'd20, 8'd15, 5'd15, 5'd3,  1'b0},
        {1'b1, 5'd31, 8'd33, 5'd1,  5'd0,  1'b1},
        {1'b0, 5'd30, 8'd35, 5'd3,  5'd1,  1'b0},
        {1'b0, 5'd0,  8'd15, 5'd15, 5'd15, 1'b0}
    };

    initial begin
        logic       fr_keep;
        logic [4:0] line_keep;

        // Reset state, R11
        do_reset();
        chk("R11 com_idx", 64'(com_idx), 64'd0);
        chk("R11 fr_out", 64'(fr_out), 64'd0);
        chk("R11 latch_stb", 64'(latch_stb), 64'd0);
        chk("R11 seg_out", 64'(seg_out), 64'd0);

        // Vector table: R1, R2, R3, R6
        for (int v = 0; v < 7; v++) begin
            do_reset();
            duty_full  = VECS[v][24];
            start_line = VECS[v][23:19];
            for (int s = 0; s < int'(VECS[v][18:11]); s++) step();
            chk("R1 line after steps", 64'(com_idx), 64'(VECS[v][10:6]));
            chk("R2 ram_row", 64'(ram_row), 64'(VECS[v][5:1]));
            chk("R3 frame polarity", 64'(fr_out), 64'(VECS[v][0]));
            chk("R6 com one-hot", 64'(com_out),
                (VECS[v][10:6] < 5'(NCOM)) ? (64'd1 << VECS[v][10:6]) : 64'd0);
        end

        // Latch strobe and segment capture, R4 / R5
        do_reset();
        duty_full = 1'b0;
        start_line = 5'd5;
        step();
        chk("R4 strobe after step", 64'(latch_stb), 64'd1);
        chk("R1 single step", 64'(com_idx), 64'd1);
        @(negedge clk);
        chk("R4 strobe one cycle", 64'(latch_stb), 64'd0);
        chk("R4 latched word", 64'(seg_out), 64'(ram_word(5'd6)));
        col_reverse = 1'b1;
        #1;
        chk("R5 mirrored word", 64'(seg_out), 64'(mirror(ram_word(5'd6))));
        col_reverse = 1'b0;

        // Display off, R7
        disp_on = 1'b0;
        #1;
        chk("R7 com blank", 64'(com_out), 64'd0);
        chk("R7 seg blank", 64'(seg_out), 64'd0);
        @(negedge clk);
        step();
        chk("R7 scan continues", 64'(com_idx), 64'd2);

        // Static drive with display on, R8
        disp_on = 1'b1;
        static_drv = 1'b1;
        #1;
        chk("R8 com all lit", 64'(com_out), 64'(16'hFFFF));
        chk("R8 seg all lit", 64'(seg_out), 64'({NSEG{1'b1}}));

        // Power save, R9
        disp_on = 1'b0;
        @(negedge clk);
        fr_keep = fr_out;
        line_keep = com_idx;
        step();
        chk("R9 no strobe", 64'(latch_stb), 64'd0);
        step();
        step();
        chk("R9 line frozen", 64'(com_idx), 64'(line_keep));
        chk("R9 fr frozen", 64'(fr_out), 64'(fr_keep));
        chk("R9 outputs blank", 64'(com_out), 64'd0);
        static_drv = 1'b0;
        disp_on = 1'b1;

        // Duty reduced while above the new limit, R1 / R3
        do_reset();
        duty_full = 1'b1;
        start_line = 5'd0;
        for (int s = 0; s < 20; s++) step();
        chk("R6 line beyond commons", 64'(com_out), 64'd0);
        duty_full = 1'b0;
        step();
        chk("R1 wrap after duty cut", 64'(com_idx), 64'd0);
        chk("R3 toggle on that wrap", 64'(fr_out), 64'd1);

        // Slave sync with simultaneous step, R10
        do_reset();
        slave_mode = 1'b1;
        fr_in = 1'b0;
        for (int s = 0; s < 3; s++) step();
        chk("R10 slave steps", 64'(com_idx), 64'd3);
        fr_in = 1'b1;
        step();
        chk("R10 edge beats step", 64'(com_idx), 64'd0);
        chk("R10 fr follows", 64'(fr_out), 64'd1);
        for (int s = 0; s < 16; s++) step();
        chk("R10 slave wrap", 64'(com_idx), 64'd0);
        chk("R10 no self toggle", 64'(fr_out), 64'd1);
        slave_mode = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule